// File: doc/BRIEF.md
# GPIO Change-Detect Interrupt Unit

This unit watches the pins of a general-purpose I/O port and tells the host when an input pin has moved away from the value the host last read. The pins are grouped into banks of equal width. Each bank has its own input-read strobe. That strobe acknowledges the bank's pending changes and records the value just read as the new reference for that bank. The comparison is made against this reference, not against the value of the previous clock. A pin that toggles and settles back before the host reads it therefore still leaves its status bit set.

Each pin has a direction bit, an interrupt mask bit and a latch-enable bit. Only pins set as inputs can flag a change. A mask bit of 1 keeps the pin off the interrupt line but still lets it record status. When a pin's latch bit is set, the first changed value is frozen in the readable input value until the host reads that bank, even if the pin returns to its earlier level. The interrupt line is active low and level-sensitive. It stays low as long as any unmasked status bit is set.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset, all status bits are 0, the readable input value is all 0, the interrupt line `irq_n_o` is 1 and every bank's reference is 0.
- R2: A pin whose direction bit is 1 (input), whose value differs from its bank's reference, sets its status bit. A level applied to `pin_i` shows in `status_o` at most 3 clock edges later (two synchronizer stages plus the status register).
- R3: A pin whose direction bit is 0 (output) never sets its status bit, whatever its level does.
- R4: A mask bit of 1 keeps its pin's status bit off the interrupt line while the status bit still sets. A mask bit of 0 lets it drive the line.
- R5: `irq_n_o` is 0 exactly while some status bit with mask 0 is set. It returns to 1 on the same edge at which a read clears the last such bit.
- R6: A pulse on `rd_input_i[b]` clears the status bits of bank b (pins b*BANK_W to b*BANK_W+BANK_W-1) and takes bank b's current readable input value as its new reference. Other banks are not affected.
- R7: With its latch bit at 1, an input pin's readable value holds the first changed level until its bank is read, even if the pin returns. After the read, a pin that now differs from the new reference sets its status again.
- R8: With its latch bit at 0, the readable value follows the synchronized pin. The status bit stays set after the pin returns, until the bank is read.
- R9: A pulse on `rd_status_i` has no effect on status, readable value or the interrupt line.
- R10: A change that reaches the comparison in the same cycle as its bank's read is not lost. Its status bit sets on a following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_BANKS*BANK_W | Raw pin levels, synchronized inside |
| dir_in_i | input | NUM_BANKS*BANK_W | 1 = pin is an input |
| mask_i | input | NUM_BANKS*BANK_W | 1 = pin blocked from the interrupt line |
| latch_i | input | NUM_BANKS*BANK_W | 1 = hold the changed value until read |
| rd_input_i | input | NUM_BANKS | Per-bank input-register read strobe |
| rd_status_i | input | NUM_BANKS | Per-bank status-register read strobe |
| status_o | output | NUM_BANKS*BANK_W | Per-pin change status |
| input_o | output | NUM_BANKS*BANK_W | Readable input value (latched or live) |
| irq_n_o | output | 1 | Active-low level interrupt |

## Verification
On every cycle, assertions check four things: a low interrupt line always has a status bit behind it, an input read leaves the bank's status empty, output pins never gain a status bit, and status bits only fall on a read. They also check that a held latched value stays still until its read, and that a status read never clears anything. Only the directed scenarios can show the rest: the three-edge latency from pin to status, the masking of the line, the return-to-level behaviour with and without the latch, the isolation between banks, and a change that coincides with a read.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned SYNC_STAGES  = 2;
  localparam int unsigned DEF_BANKS    = 2;
  localparam int unsigned DEF_BANK_W   = 8;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = gpio_chg_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_bank.sv
module gpio_chg_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] latch_i,
  input  logic         rd_i,
  input  logic         rd_stat_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] value_o,
  output logic         req_nxt_o
);
  logic [W-1:0] ref_q, held_q, hold_q, status_q, value_q;
  logic [W-1:0] eff, diff, capture;
  logic [W-1:0] status_nxt, hold_nxt, held_nxt, value_nxt, ref_nxt;

  always_comb begin
    eff        = (hold_q & held_q) | (~hold_q & live_i);
    diff       = dir_i & (eff ^ ref_q);
    capture    = latch_i & dir_i & ~hold_q & (live_i ^ ref_q);
    status_nxt = rd_i ? '0 : (status_q | diff);
    hold_nxt   = rd_i ? '0 : (hold_q | capture);
    held_nxt   = (capture & live_i) | (~capture & held_q);
    value_nxt  = (hold_nxt & held_nxt) | (~hold_nxt & live_i);
    ref_nxt    = rd_i ? value_q : ref_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= '0;
      held_q   <= '0;
      hold_q   <= '0;
      status_q <= '0;
      value_q  <= '0;
    end else begin
      ref_q    <= ref_nxt;
      held_q   <= held_nxt;
      hold_q   <= hold_nxt;
      status_q <= status_nxt;
      value_q  <= value_nxt;
    end
  end

  assign status_o  = status_q;
  assign value_o   = value_q;
  assign req_nxt_o = |(status_nxt & ~mask_i);

  // R6: a read leaves the bank with no pending status
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (status_q == '0));

  // R3: output pins never gain a status bit
  a_r3_no_output_status: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> ((status_q & ~$past(status_q) & ~$past(dir_i)) == '0));

  // R8: status bits fall only on a read
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (($past(status_q) & ~status_q) == '0));

  // R7: a held latched value does not move before its read
  a_r7_held_stable: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (((value_q ^ $past(value_q)) & $past(hold_q)) == '0));

  // R9: a status read alone never clears status
  a_r9_stat_read_no_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_stat_i && !rd_i) |=> (($past(status_q) & ~status_q) == '0));
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int unsigned NUM_BANKS = gpio_chg_pkg::DEF_BANKS,
  parameter int unsigned BANK_W    = gpio_chg_pkg::DEF_BANK_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   dir_in_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   mask_i,
  input  logic [NUM_BANKS*BANK_W-1:0]   latch_i,
  input  logic [NUM_BANKS-1:0]          rd_input_i,
  input  logic [NUM_BANKS-1:0]          rd_status_i,
  output logic [NUM_BANKS*BANK_W-1:0]   status_o,
  output logic [NUM_BANKS*BANK_W-1:0]   input_o,
  output logic                          irq_n_o
);
  localparam int unsigned NPINS = NUM_BANKS * BANK_W;

  logic [NPINS-1:0]     live;
  logic [NUM_BANKS-1:0] req_nxt;
  logic                 irq_n_q;

  gpio_chg_sync #(.WIDTH(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (live)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_chg_bank #(.W(BANK_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .live_i    (live[b*BANK_W +: BANK_W]),
      .dir_i     (dir_in_i[b*BANK_W +: BANK_W]),
      .mask_i    (mask_i[b*BANK_W +: BANK_W]),
      .latch_i   (latch_i[b*BANK_W +: BANK_W]),
      .rd_i      (rd_input_i[b]),
      .rd_stat_i (rd_status_i[b]),
      .status_o  (status_o[b*BANK_W +: BANK_W]),
      .value_o   (input_o[b*BANK_W +: BANK_W]),
      .req_nxt_o (req_nxt[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|req_nxt;
  end

  assign irq_n_o = irq_n_q;

  // R5: a low interrupt line is always backed by a status bit
  a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> (|status_o));

  // R5: with no status at all the line is released
  a_r5_idle_released: assert property (@(posedge clk) disable iff (rst)
    (status_o == '0) |-> irq_n_o);
endmodule

// File: tb/test_gpio_chg_irq.sv
module test_gpio_chg_irq;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int NP = NB * BW;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin, dir, mask, latch, status, inval;
  logic [NB-1:0] rd_in, rd_st;
  logic          irq_n;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  gpio_chg_irq #(.NUM_BANKS(NB), .BANK_W(BW)) i_gpio_chg_irq (
    .clk(clk), .rst(rst), .pin_i(pin), .dir_in_i(dir), .mask_i(mask),
    .latch_i(latch), .rd_input_i(rd_in), .rd_status_i(rd_st),
    .status_o(status), .input_o(inval), .irq_n_o(irq_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_bank(input int b);
    rd_in[b] = 1'b1;
    step(1);
    rd_in[b] = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; pin = '0; dir = '1; mask = '0; latch = '0; rd_in = '0; rd_st = '0;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 input", 32'(inval), 32'h0);
    chk("R1 irq_n", 32'(irq_n), 32'h1);
    step(4);
    chk("R1 reference zero, no spurious status", 32'(status), 32'h0);
  endtask

  task automatic t_basic();
    pin[3] = 1'b1;
    step(3);
    chk("R2 status after 3 edges", 32'(status), 32'h0008);
    chk("R5 irq asserted", 32'(irq_n), 32'h0);
    chk("R8 input follows pin", 32'(inval), 32'h0008);
    read_bank(0);
    chk("R6 read clears status", 32'(status), 32'h0);
    chk("R5 irq released on read", 32'(irq_n), 32'h1);
    step(3);
    chk("R6 new reference taken", 32'(status), 32'h0);
  endtask

  task automatic t_banks();
    pin[9] = 1'b1; pin[0] = 1'b1;
    step(4);
    chk("R2 two banks", 32'(status), 32'h0201);
    read_bank(1);
    chk("R6 bank1 read only clears bank1", 32'(status), 32'h0001);
    chk("R5 irq held by bank0", 32'(irq_n), 32'h0);
    read_bank(0);
    chk("R6 bank0 cleared", 32'(status), 32'h0);
  endtask

  task automatic t_output_pin();
    dir[4] = 1'b0;
    pin[4] = 1'b1;
    step(4);
    chk("R3 output pin no status", 32'(status), 32'h0);
    chk("R3 output pin no irq", 32'(irq_n), 32'h1);
    pin[4] = 1'b0;
    step(4);
    dir[4] = 1'b1;
    step(3);
    chk("R3 status still clear", 32'(status), 32'h0);
  endtask

  task automatic t_mask();
    mask[6] = 1'b1;
    pin[6] = 1'b1;
    step(4);
    chk("R4 masked pin sets status", 32'(status), 32'h0040);
    chk("R4 masked pin no irq", 32'(irq_n), 32'h1);
    mask[6] = 1'b0;
    step(2);
    chk("R4 unmask drives irq", 32'(irq_n), 32'h0);
    read_bank(0);
    chk("R5 irq released", 32'(irq_n), 32'h1);
  endtask

  task automatic t_nolatch();
    pin[5] = 1'b1;
    step(4);
    pin[5] = 1'b0;
    step(4);
    chk("R8 status sticky after return", 32'(status), 32'h0020);
    chk("R8 input back to pin level", 32'(inval & 16'h0020), 32'h0);
    read_bank(0);
    step(3);
    chk("R8 no new change after read", 32'(status), 32'h0);
  endtask

  task automatic t_latch();
    latch[7] = 1'b1;
    pin[7] = 1'b1;
    step(4);
    pin[7] = 1'b0;
    step(4);
    chk("R7 latched value held", 32'(inval & 16'h0080), 32'h0080);
    chk("R7 status set", 32'(status), 32'h0080);
    read_bank(0);
    chk("R7 value released on read", 32'(inval & 16'h0080), 32'h0);
    step(2);
    chk("R7 return seen as new change", 32'(status), 32'h0080);
    read_bank(0);
    step(3);
    chk("R7 settled after second read", 32'(status), 32'h0);
    latch[7] = 1'b0;
  endtask

  task automatic t_stat_read();
    pin[1] = 1'b1;
    step(4);
    rd_st[0] = 1'b1;
    step(1);
    rd_st[0] = 1'b0;
    step(2);
    chk("R9 status read does not clear", 32'(status), 32'h0002);
    chk("R9 irq unchanged", 32'(irq_n), 32'h0);
    read_bank(0);
  endtask

  task automatic t_same_cycle();
    pin[11] = 1'b1;
    step(2);
    rd_in[1] = 1'b1;
    step(1);
    rd_in[1] = 1'b0;
    chk("R10 read edge clears", 32'(status), 32'h0);
    step(2);
    chk("R10 coincident change kept", 32'(status), 32'h0800);
    chk("R10 irq raised", 32'(irq_n), 32'h0);
    read_bank(1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_banks();
    t_output_pin();
    t_mask();
    t_nolatch();
    t_latch();
    t_stat_read();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule